// File: doc/BRIEF.md
# Deep Standby Power Mode Controller

This block is the state machine that takes a small processor subsystem from normal run into a deep standby state and back. In standby only the source oscillator and the free-running timebase keep running. The core and peripheral clock gates are closed, and a retain enable keeps registers and RAM contents valid. External pins either keep their last state or float, as chosen by the entry write. A pending interrupt or an external reset wakes the block. Every wake first passes through an oscillation stabilization wait, counted in timebase overflow ticks, before the PLL clock can be used again.

Software requests standby with one control write carrying three fields: a stop request, a clock-source select (1 = main oscillator, 0 = PLL) and a pin float select. The clock-select field is stored on every write. The stop request is acted on in the same cycle and is never stored, so it clears itself. The stabilization length `stab_ticks` is a tick count. With a 2^11-cycle timebase tick, a count of 8 gives the usual 2^14 oscillator cycles.

The FSM has four states: RUN, SBY (standby), WAIT (stabilization) and RST (reset state). Its transitions are:
- RUN->SBY on a valid entry write.
- RUN->RST on an external reset.
- SBY->WAIT on an interrupt or an external reset.
- WAIT->RUN when the count expires after an interrupt wake.
- WAIT->RST when the count expires after a reset wake.
- RST->RUN when the external reset is released.

Top module: `deep_standby_ctrl`

## Requirements
- R1: After power-on reset (`rst_n` low) the block is in RUN with core and peripheral clocks enabled and `sel_main_clk`=1 (main clock). `pin_hold`, `pin_hiz`, `retain_en`, `stab_wait`, `stab_done` and `cpu_rst` are all 0.
- R2: A write with `ctl_stop`=1 and `ctl_main`=0, made while `irq_pend` and `ext_rst` are low, enters SBY at the next edge. This holds whether the stored clock select was PLL or main.
- R3: A write with `ctl_stop`=1 and `ctl_main`=1 does not enter standby. The clock select stays main (`sel_main_clk`=1).
- R4: A stop request written while `irq_pend`=1 is ignored and the block stays in RUN. The clock-select field of that write is still stored.
- R5: In SBY, `core_clk_en`=0, `periph_clk_en`=0, `retain_en`=1 and `sel_main_clk`=1.
- R6: The `ctl_float` value of the entering write decides the pins for the whole of SBY: 1 gives `pin_hiz`=1 and `pin_hold`=0; 0 gives `pin_hold`=1 and `pin_hiz`=0. Both are 0 in every other state.
- R7: `irq_pend`=1 in SBY moves the block to WAIT. WAIT has `stab_wait`=1 and `retain_en`=1, and for an interrupt wake both clock enables stay 0.
- R8: WAIT ends at the edge that samples the N-th `tb_tick` high, where N=`stab_ticks` (0 acts as 1). `stab_done` is 1 for the single cycle after that edge. Ticks outside WAIT are not counted.
- R9: After an interrupt wake the block returns to RUN using the stored clock select, so a PLL selection gives `sel_main_clk`=0.
- R10: A wake by `ext_rst`, or an `ext_rst` arriving during WAIT, marks the wake as a reset wake. The reset sequence then runs on the main clock: `cpu_rst`=1, `core_clk_en`=1, `sel_main_clk`=1. When the wait ends the block enters RST, which holds `cpu_rst`=1 until `ext_rst` is low.
- R11: An external reset does not change the stored clock select, so RST and the following RUN keep the PLL selection (`sel_main_clk`=0).
- R12: `ext_rst` in RUN moves the block to RST at the next edge, with both clocks on and `cpu_rst`=1. RST returns to RUN once `ext_rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source oscillator clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| ctl_wr | input | 1 | Control write strobe |
| ctl_stop | input | 1 | Stop request field of the write |
| ctl_main | input | 1 | Clock-source field of the write (1 = main, 0 = PLL) |
| ctl_float | input | 1 | Pin field of the write (1 = float, 0 = hold) |
| irq_pend | input | 1 | Any interrupt request pending |
| ext_rst | input | 1 | External reset, active high, synchronous |
| tb_tick | input | 1 | Timebase overflow tick |
| stab_ticks | input | CNT_W | Stabilization wait length in ticks |
| core_clk_en | output | 1 | CPU clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| sel_main_clk | output | 1 | 1 = system runs on main clock, 0 = PLL |
| pin_hold | output | 1 | Hold external pins at their last state |
| pin_hiz | output | 1 | Float external pins |
| retain_en | output | 1 | Register and RAM retention enable |
| stab_wait | output | 1 | Stabilization wait in progress |
| stab_done | output | 1 | One-cycle pulse when the wait count expires |
| cpu_rst | output | 1 | Reset state driven to the CPU |

## Verification
The bench goes after the entry vetoes:
- If a stop request with the main clock still selected entered standby, the clocks would be gated while software expected them to run.
- If the interrupt veto were missing, the block would go to sleep with an interrupt pending and lose it.

It counts wait ticks exactly and checks the one-cycle done pulse. An off-by-one counter would release the PLL a tick early or late.

For reset wakes it covers three cases:
- a reset shorter than the wait;
- a reset that outlasts it;
- a reset that arrives mid-wait after an interrupt wake.

A design that dropped the reset cause would return to RUN without resetting the CPU. A design that reloaded the clock select on reset would silently switch to the main clock.

// File: rtl/sby_pkg.sv
package sby_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_SBY  = 2'd1,
        ST_WAIT = 2'd2,
        ST_RST  = 2'd3
    } sby_state_e;

    typedef struct packed {
        logic core_en;
        logic periph_en;
        logic sel_main;
        logic pin_hold;
        logic pin_hiz;
        logic retain_en;
        logic stab_wait;
        logic cpu_rst;
    } sby_out_t;

endpackage

// File: rtl/sby_clksel.sv
module sby_clksel (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wr_main,
    output logic clk_main
);
    // Clock-source select bit: only power-on reset and writes touch it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_main <= 1'b1;
        end else if (wr) begin
            clk_main <= wr_main;
        end
    end

    // R11: nothing but a write may change the selection
    a_r11_sel_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(clk_main));
endmodule

// File: rtl/sby_stab_cnt.sv
module sby_stab_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] len,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
    assign expire  = run & tick & (cnt_inc >= {1'b0, len});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt_inc[CNT_W-1:0];
        end
    end

    // R8: without a tick the count does not advance during the wait
    a_r8_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(cnt));
endmodule

// File: rtl/sby_fsm.sv
module sby_fsm
    import sby_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic       ctl_stop,
    input  logic       ctl_main,
    input  logic       ctl_float,
    input  logic       irq_pend,
    input  logic       ext_rst,
    input  logic       expire,
    input  logic       clk_main,
    output logic       count_run,
    output logic       stab_done,
    output sby_out_t   outs
);
    sby_state_e st, st_nxt;
    logic       pin_float_q;
    logic       cause_rst_q;
    logic       entry_ok;

    assign entry_ok  = ctl_wr & ctl_stop & ~ctl_main & ~irq_pend & ~ext_rst;
    assign count_run = (st == ST_WAIT);

    // Next-state logic
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_RUN: begin
                if (ext_rst)       st_nxt = ST_RST;
                else if (entry_ok) st_nxt = ST_SBY;
            end
            ST_SBY: begin
                if (ext_rst || irq_pend) st_nxt = ST_WAIT;
            end
            ST_WAIT: begin
                if (expire) st_nxt = (cause_rst_q || ext_rst) ? ST_RST : ST_RUN;
            end
            ST_RST: begin
                if (!ext_rst) st_nxt = ST_RUN;
            end
            default: st_nxt = ST_RUN;
        endcase
    end

    // State register and the registers tied to transitions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st          <= ST_RUN;
            pin_float_q <= 1'b0;
            cause_rst_q <= 1'b0;
            stab_done   <= 1'b0;
        end else begin
            st        <= st_nxt;
            stab_done <= expire;
            if (st == ST_RUN && st_nxt == ST_SBY) begin
                pin_float_q <= ctl_float;
            end
            if (st == ST_SBY && st_nxt == ST_WAIT) begin
                cause_rst_q <= ext_rst;
            end else if (st == ST_WAIT && ext_rst) begin
                cause_rst_q <= 1'b1;
            end
        end
    end

    // Output decode
    always_comb begin
        outs = '0;
        unique case (st)
            ST_RUN: begin
                outs.core_en   = 1'b1;
                outs.periph_en = 1'b1;
                outs.sel_main  = clk_main;
            end
            ST_SBY: begin
                outs.sel_main  = 1'b1;
                outs.retain_en = 1'b1;
                outs.pin_hiz   = pin_float_q;
                outs.pin_hold  = ~pin_float_q;
            end
            ST_WAIT: begin
                outs.sel_main  = 1'b1;
                outs.retain_en = 1'b1;
                outs.stab_wait = 1'b1;
                outs.core_en   = cause_rst_q;
                outs.cpu_rst   = cause_rst_q;
            end
            ST_RST: begin
                outs.core_en   = 1'b1;
                outs.periph_en = 1'b1;
                outs.sel_main  = clk_main;
                outs.cpu_rst   = 1'b1;
            end
            default: outs = '0;
        endcase
    end

    // R2: standby is only ever reached from a valid entry write
    a_r2_entry_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN) |=> (st != ST_SBY || $past(ctl_wr && ctl_stop && !ctl_main && !irq_pend)));
    // R4: a pending interrupt vetoes entry
    a_r4_irq_veto: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && irq_pend) |=> (st != ST_SBY));
    // R6: pin mode frozen for the whole standby period
    a_r6_pin_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SBY) |=> (st != ST_SBY || $stable(pin_float_q)));
    // R7: standby is left only into the stabilization wait
    a_r7_wake_via_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SBY) |=> (st == ST_SBY || st == ST_WAIT));
    // R8: done pulse only follows a wait cycle
    a_r8_done_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
        stab_done |-> $past(st == ST_WAIT));
    // R10: a reset wake never ends directly in RUN
    a_r10_reset_wake_to_rst: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT && cause_rst_q) |=> (st == ST_WAIT || st == ST_RST));
endmodule

// File: rtl/deep_standby_ctrl.sv
module deep_standby_ctrl
    import sby_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_stop,
    input  logic             ctl_main,
    input  logic             ctl_float,
    input  logic             irq_pend,
    input  logic             ext_rst,
    input  logic             tb_tick,
    input  logic [CNT_W-1:0] stab_ticks,
    output logic             core_clk_en,
    output logic             periph_clk_en,
    output logic             sel_main_clk,
    output logic             pin_hold,
    output logic             pin_hiz,
    output logic             retain_en,
    output logic             stab_wait,
    output logic             stab_done,
    output logic             cpu_rst
);
    logic     clk_main;
    logic     count_run;
    logic     expire;
    sby_out_t outs;

    sby_clksel u_clksel (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (ctl_wr),
        .wr_main  (ctl_main),
        .clk_main (clk_main)
    );

    sby_stab_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (count_run),
        .tick   (tb_tick),
        .len    (stab_ticks),
        .expire (expire)
    );

    sby_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_stop  (ctl_stop),
        .ctl_main  (ctl_main),
        .ctl_float (ctl_float),
        .irq_pend  (irq_pend),
        .ext_rst   (ext_rst),
        .expire    (expire),
        .clk_main  (clk_main),
        .count_run (count_run),
        .stab_done (stab_done),
        .outs      (outs)
    );

    assign core_clk_en   = outs.core_en;
    assign periph_clk_en = outs.periph_en;
    assign sel_main_clk  = outs.sel_main;
    assign pin_hold      = outs.pin_hold;
    assign pin_hiz       = outs.pin_hiz;
    assign retain_en     = outs.retain_en;
    assign stab_wait     = outs.stab_wait;
    assign cpu_rst       = outs.cpu_rst;

    // R5: clocks gated whenever retention is on outside a reset sequence
    a_r5_gated_when_retained: assert property (@(posedge clk) disable iff (!rst_n)
        (retain_en && !cpu_rst) |-> (!core_clk_en && !periph_clk_en));
    // R6: pins never held and floated at once
    a_r6_pins_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pin_hold && pin_hiz));
endmodule

// File: tb/tb_deep_standby_ctrl.sv
`timescale 1ns/100ps
module tb_deep_standby_ctrl;
    localparam int CNT_W = 8;
    // vector order: core periph sel | hold hiz ret | wait done rst
    localparam logic [8:0] RUN_MAIN = 9'b111_000_000;
    localparam logic [8:0] RUN_PLL  = 9'b110_000_000;
    localparam logic [8:0] SBY_HOLD = 9'b001_101_000;
    localparam logic [8:0] SBY_HIZ  = 9'b001_011_000;
    localparam logic [8:0] WAIT_IRQ = 9'b001_001_100;
    localparam logic [8:0] WAIT_RST = 9'b101_001_101;
    localparam logic [8:0] RST_PLL  = 9'b110_000_001;
    localparam logic [8:0] DONE     = 9'b000_000_010;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ctl_wr = 0, ctl_stop = 0, ctl_main = 0, ctl_float = 0;
    logic irq_pend = 0, ext_rst = 0, tb_tick = 0;
    logic [CNT_W-1:0] stab_ticks = 8'd3;
    logic core_clk_en, periph_clk_en, sel_main_clk, pin_hold, pin_hiz;
    logic retain_en, stab_wait, stab_done, cpu_rst;

    always #2 clk = ~clk;

    deep_standby_ctrl #(.CNT_W(CNT_W)) dut (.*);

    typedef struct { logic [8:0] exp; string req; } item_t;
    item_t q[$];
    event  mon_ev;
    int    n_chk = 0, n_fail = 0;
    bit    finished = 0;

    // Monitor: pops expected items and compares with the ports
    initial forever begin
        @(mon_ev);
        while (q.size() > 0) begin
            item_t it;
            logic [8:0] act;
            it  = q.pop_front();
            act = {core_clk_en, periph_clk_en, sel_main_clk, pin_hold, pin_hiz,
                   retain_en, stab_wait, stab_done, cpu_rst};
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: outputs actual %b expected %b", it.req, act, it.exp);
            end
        end
    end

    // Driver side: push an expectation, sampled mid-low-phase
    task automatic expect_out(input logic [8:0] e, input string req);
        item_t it;
        #0.5;
        it.exp = e; it.req = req;
        q.push_back(it);
        -> mon_ev;
        #0.1;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write(input logic stp, input logic mn, input logic fl);
        ctl_wr = 1; ctl_stop = stp; ctl_main = mn; ctl_float = fl;
        @(negedge clk);
        ctl_wr = 0; ctl_stop = 0; ctl_main = 0; ctl_float = 0;
    endtask

    task automatic tick1();
        tb_tick = 1;
        @(negedge clk);
        tb_tick = 0;
    endtask

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(1);
        expect_out(RUN_MAIN, "R1 reset state");

        write(1, 1, 0);
        expect_out(RUN_MAIN, "R3 stop with main select ignored");
        cyc(2);
        expect_out(RUN_MAIN, "R3 still run");

        irq_pend = 1;
        write(1, 0, 0);
        expect_out(RUN_PLL, "R4 irq veto, select stored");
        irq_pend = 0;
        tick1();                       // tick in RUN, not counted (R8)

        write(1, 0, 0);
        expect_out(SBY_HOLD, "R2 entry from PLL select");
        tick1(); tick1(); cyc(3);
        expect_out(SBY_HOLD, "R5 R6 standby holds pins");

        irq_pend = 1; cyc(1); irq_pend = 0;
        expect_out(WAIT_IRQ, "R7 irq wake to wait");
        tick1(); cyc(2);
        expect_out(WAIT_IRQ, "R8 one of three ticks");
        tick1(); cyc(1);
        expect_out(WAIT_IRQ, "R8 two of three ticks");
        tick1();
        expect_out(RUN_PLL | DONE, "R8 R9 wait done, back to PLL run");
        cyc(1);
        expect_out(RUN_PLL, "R8 done is one cycle");

        write(0, 1, 0);
        expect_out(RUN_MAIN, "R3 select main");
        write(1, 0, 1);
        expect_out(SBY_HIZ, "R2 R6 entry from main select, float");

        stab_ticks = 8'd2;
        ext_rst = 1; cyc(1);
        expect_out(WAIT_RST, "R10 reset wake runs on main clock");
        cyc(1); ext_rst = 0; cyc(1);
        expect_out(WAIT_RST, "R10 short reset, wait continues");
        tick1(); tick1();
        expect_out(RST_PLL | DONE, "R10 R11 wait done into reset state");
        cyc(1);
        expect_out(RUN_PLL, "R11 PLL select kept after reset");

        write(1, 0, 0);
        irq_pend = 1; cyc(1); irq_pend = 0;
        expect_out(WAIT_IRQ, "R7 second irq wake");
        stab_ticks = 8'd0;
        ext_rst = 1; cyc(1);
        expect_out(WAIT_RST, "R10 reset during wait");
        tick1();
        expect_out(RST_PLL | DONE, "R8 R10 zero count acts as one tick");
        cyc(3);
        expect_out(RST_PLL, "R10 long reset holds reset state");
        ext_rst = 0; cyc(1);
        expect_out(RUN_PLL, "R10 release to run");

        ext_rst = 1; cyc(1);
        expect_out(RST_PLL, "R12 reset in run");
        ext_rst = 0; cyc(1);
        expect_out(RUN_PLL, "R12 release, select unchanged");

        cyc(2);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule